// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a bus master and classifies every access it is shown as permitted or faulting. Software programs eight protection regions through a small register port. Each region has a base address, a power-of-two size, an eight-way subregion disable mask, an access-permission code and an execute-never bit. The decision depends on the access address, its direction, whether it is an instruction fetch, the privilege level and whether the master is running in a non-maskable or hard-fault handler.

The result is combinational in the cycle the access is presented. When an access faults, its address is latched into a fault-address register and a sticky valid flag is set. The flag stays set until software clears it, and while it is set no later fault overwrites the stored address. The memory-type bits in each attribute word are stored and read back, but they play no part in the decision.

Top module: `mem_guard`

## Requirements
- R1: The register port has six registers, chosen by `cfg_sel`: 0 control, 1 region index, 2 base of the selected region, 3 attribute of the selected region, 4 status, 5 fault address. In the control register, bit 0 enables checking, bit 1 keeps checking on in handler context and bit 2 allows privileged access to unmapped space. Attribute bits are: enable at 0, size code at 5:1, subregion mask at 15:8, memory type at 21:16, permission code at 26:24, execute-never at 28. All other attribute bits read 0. After reset every register reads 0.
- R2: Region index values 0..7 select which region registers 2 and 3 access. A base write keeps bits 31:5, and bits 4:0 read back as 0.
- R3: While control bit 0 is 0, every valid access is permitted.
- R4: A region with size code S spans 2^(S+1) bytes. Only address bits above bit S are compared with the base. Size codes below 4 behave as 4, which gives 32 bytes.
- R5: Each subregion mask bit k disables the k-th eighth of its region. An access in a disabled eighth does not match that region.
- R6: When several enabled regions match, the highest-numbered one decides. A region whose enable bit is 0 never matches.
- R7: Permission codes, given as privileged/unprivileged: 1 = rw/none, 2 = rw/ro, 3 = rw/rw, 5 = ro/none, 6 = ro/ro. Codes 0, 4 and 7 give no access to anyone. An instruction fetch counts as a read.
- R8: A fetch that hits a region with execute-never set faults, whatever its permission code.
- R9: An access that matches no region is permitted only when it is privileged and control bit 2 is 1. An unprivileged unmatched access always faults.
- R10: In handler context, when control bit 1 is 0, every access is permitted. When control bit 1 is 1, handler-context accesses are checked normally.
- R11: With `acc_valid` high, exactly one of `acc_permit` and `acc_fault` is high, in the same cycle. With `acc_valid` low, both are low. A fault with the status flag clear sets status bit 0 at the next edge and stores the access address in register 5.
- R12: While status bit 0 is set, later faults leave register 5 unchanged. Writing 1 to status bit 0 clears the flag.
- R13: The memory-type bits 21:16 read back as written and do not change any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel` (combinational) |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_priv | input | 1 | Access is privileged |
| acc_hfctx | input | 1 | Master is in a non-maskable or hard-fault handler |
| acc_permit | output | 1 | Access allowed |
| acc_fault | output | 1 | Access violates protection |

## Verification
The checker assumes that access inputs are steady for the whole cycle in which `acc_valid` is high. It also assumes that a status clear is a single-cycle write strobe and is never left asserted. The bench changes inputs only on falling edges and pulses `cfg_wr` for exactly one rising edge. The bench also assumes that software keeps each base aligned to its region size; every region it programs is aligned, so the masked comparison matches the intended span.

// File: rtl/mem_guard.sv
module mem_guard #(
  parameter int NREG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic        acc_write,
  input  logic        acc_fetch,
  input  logic        acc_priv,
  input  logic        acc_hfctx,
  output logic        acc_permit,
  output logic        acc_fault
);
  localparam int IW = $clog2(NREG);
  localparam logic [31:0] ATTR_MASK = 32'h173F_FF3F;

  logic [2:0]    ctrl_q;
  logic [IW-1:0] idx_q;
  logic [31:0]   base_q [NREG];
  logic [31:0]   attr_q [NREG];
  logic          flag_q;
  logic [31:0]   faddr_q;

  logic [NREG-1:0] hit;
  logic [IW-1:0]   win;
  logic            any_hit;

  wire chk_on   = ctrl_q[0];
  wire hf_on    = ctrl_q[1];
  wire priv_def = ctrl_q[2];
  wire clr      = cfg_wr && cfg_sel == 3'd4 && cfg_wdata[0];

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    logic [4:0]  sz;
    logic [32:0] span;
    logic [2:0]  eighth;
    logic [7:0]  srd;
    assign sz     = (attr_q[g][5:1] < 5'd4) ? 5'd4 : attr_q[g][5:1];
    assign span   = (33'd1 << ({1'b0, sz} + 6'd1)) - 33'd1;
    assign eighth = 3'(acc_addr >> (sz - 5'd2));
    assign srd    = attr_q[g][15:8];
    assign hit[g] = attr_q[g][0]
                 && (((acc_addr ^ base_q[g]) & ~span[31:0]) == 32'd0)
                 && !srd[eighth];
  end

  always_comb begin
    win = '0;
    any_hit = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        win = IW'(i);
        any_hit = 1'b1;
      end
    end
  end

  wire [2:0] ap = attr_q[win][26:24];
  wire       xn = attr_q[win][28];

  logic p_rd, p_wr, u_rd, u_wr;
  always_comb begin
    {p_rd, p_wr, u_rd, u_wr} = 4'b0000;
    case (ap)
      3'd1: {p_rd, p_wr, u_rd, u_wr} = 4'b1100;
      3'd2: {p_rd, p_wr, u_rd, u_wr} = 4'b1110;
      3'd3: {p_rd, p_wr, u_rd, u_wr} = 4'b1111;
      3'd5: {p_rd, p_wr, u_rd, u_wr} = 4'b1000;
      3'd6: {p_rd, p_wr, u_rd, u_wr} = 4'b1010;
      default: ;
    endcase
  end

  wire can_rd = acc_priv ? p_rd : u_rd;
  wire can_wr = acc_priv ? p_wr : u_wr;
  wire hit_ok = acc_fetch ? (!xn && can_rd) : (acc_write ? can_wr : can_rd);
  wire ok     = !chk_on || (acc_hfctx && !hf_on) ||
                (any_hit ? hit_ok : (acc_priv && priv_def));

  assign acc_permit = acc_valid && ok;
  assign acc_fault  = acc_valid && !ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      idx_q   <= '0;
      flag_q  <= 1'b0;
      faddr_q <= '0;
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= '0;
        attr_q[i] <= '0;
      end
    end else begin
      if (cfg_wr) begin
        case (cfg_sel)
          3'd0: ctrl_q <= cfg_wdata[2:0];
          3'd1: idx_q  <= cfg_wdata[IW-1:0];
          3'd2: base_q[idx_q] <= {cfg_wdata[31:5], 5'd0};
          3'd3: attr_q[idx_q] <= cfg_wdata & ATTR_MASK;
          default: ;
        endcase
      end
      if (clr) begin
        flag_q <= 1'b0;
      end else if (acc_fault && !flag_q) begin
        flag_q  <= 1'b1;
        faddr_q <= acc_addr;
      end
    end
  end

  always_comb begin
    case (cfg_sel)
      3'd0:    cfg_rdata = {29'd0, ctrl_q};
      3'd1:    cfg_rdata = 32'(idx_q);
      3'd2:    cfg_rdata = base_q[idx_q];
      3'd3:    cfg_rdata = attr_q[idx_q];
      3'd4:    cfg_rdata = {31'd0, flag_q};
      3'd5:    cfg_rdata = faddr_q;
      default: cfg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [2:0]  cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic        acc_valid,
  input logic [31:0] acc_addr,
  input logic        acc_hfctx,
  input logic        acc_permit,
  input logic        acc_fault,
  input logic [2:0]  ctrl,
  input logic        flag,
  input logic [31:0] faddr
);
  wire clr = cfg_wr && cfg_sel == 3'd4 && cfg_wdata[0];

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_permit && !acc_fault);

  p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_permit ^ acc_fault));

  p_off_permits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !ctrl[0] |-> acc_permit);

  p_handler_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_hfctx && !ctrl[1] |-> acc_permit);

  p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault && !flag && !clr |=> flag && faddr == $past(acc_addr));

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag && $stable(faddr));

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);
endmodule

bind mem_guard mem_guard_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_hfctx(acc_hfctx), .acc_permit(acc_permit), .acc_fault(acc_fault),
  .ctrl(ctrl_q), .flag(flag_q), .faddr(faddr_q)
);

// File: tb/test_mem_guard.sv
module test_mem_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = 32'd0;
  logic        acc_write = 1'b0, acc_fetch = 1'b0, acc_priv = 1'b0, acc_hfctx = 1'b0;
  logic        acc_permit, acc_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mem_guard i_mem_guard (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_fetch(acc_fetch),
    .acc_priv(acc_priv), .acc_hfctx(acc_hfctx), .acc_permit(acc_permit),
    .acc_fault(acc_fault)
  );

  // {ctrl, addr, {write, fetch, priv, hfctx}, expected permit, requirement}
  localparam int NV = 28;
  localparam logic [43:0] VEC [NV] = '{
    {3'd1, 32'h0000_1000, 4'b0010, 1'b1, 4'd7},  // R7 priv read, code 5
    {3'd1, 32'h0000_1000, 4'b1010, 1'b0, 4'd7},  // R7 priv write, code 5
    {3'd1, 32'h0000_1000, 4'b0000, 1'b0, 4'd7},  // R7 user read, code 5
    {3'd1, 32'h0000_0100, 4'b0110, 1'b1, 4'd8},  // R8 fetch, XN clear
    {3'd1, 32'h2000_1000, 4'b0000, 1'b1, 4'd7},  // R7 code 3 user read
    {3'd1, 32'h2000_7FFC, 4'b1000, 1'b1, 4'd4},  // R4 last word of 32 KB
    {3'd1, 32'h2000_1000, 4'b0110, 1'b0, 4'd8},  // R8 fetch from XN region
    {3'd1, 32'h2000_0080, 4'b0010, 1'b0, 4'd6},  // R6 guard overrides lower
    {3'd1, 32'h2000_0100, 4'b0010, 1'b1, 4'd4},  // R4 just past guard
    {3'd1, 32'h4000_0000, 4'b0010, 1'b1, 4'd7},  // R7 code 1 priv
    {3'd1, 32'h4000_0000, 4'b0000, 1'b0, 4'd7},  // R7 code 1 user
    {3'd1, 32'h4400_0000, 4'b0010, 1'b0, 4'd5},  // R5 disabled eighth, no default
    {3'd5, 32'h4400_0000, 4'b0010, 1'b1, 4'd9},  // R9 default map for priv
    {3'd5, 32'h4400_0000, 4'b0000, 1'b0, 4'd9},  // R9 user unmatched
    {3'd1, 32'h4800_0000, 4'b0010, 1'b1, 4'd5},  // R5 next eighth enabled
    {3'd1, 32'h6000_0010, 4'b0000, 1'b1, 4'd13}, // R13 code 6 with type bits
    {3'd1, 32'h6000_0010, 4'b1000, 1'b0, 4'd13}, // R13 code 6 user write
    {3'd1, 32'h6000_0020, 4'b0000, 1'b0, 4'd4},  // R4 clamped 32 B end
    {3'd1, 32'h8000_03FC, 4'b0000, 1'b1, 4'd7},  // R7 code 2 user read
    {3'd1, 32'h8000_03FC, 4'b1000, 1'b0, 4'd6},  // R6 disabled region 7 ignored
    {3'd1, 32'h8000_03FC, 4'b1010, 1'b1, 4'd7},  // R7 code 2 priv write
    {3'd1, 32'h8000_0400, 4'b0000, 1'b0, 4'd4},  // R4 past 1 KB
    {3'd1, 32'h9000_0000, 4'b0010, 1'b0, 4'd7},  // R7 reserved code 4
    {3'd0, 32'h9000_0000, 4'b1000, 1'b1, 4'd3},  // R3 checking off
    {3'd1, 32'h9000_0000, 4'b1001, 1'b1, 4'd10}, // R10 handler bypass
    {3'd3, 32'h9000_0000, 4'b1001, 1'b0, 4'd10}, // R10 handler checked
    {3'd5, 32'hF000_0000, 4'b1010, 1'b1, 4'd9},  // R9 priv default write
    {3'd4, 32'hF000_0000, 4'b0000, 1'b1, 4'd3}   // R3 off even with default bit
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    cfg_sel = s; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, input string req, input logic [31:0] exp);
    cfg_sel = s; #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic region(input int i, input logic [31:0] b, input logic [31:0] a);
    wr(3'd1, 32'(i)); wr(3'd2, b); wr(3'd3, a);
  endtask

  task automatic access(input logic [31:0] a, input logic [3:0] k);
    acc_addr = a; {acc_write, acc_fetch, acc_priv, acc_hfctx} = k; acc_valid = 1'b1;
    #2;
  endtask

  task automatic finish_access();
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    rd(3'd0, "R1 ctrl reset", 32'd0);
    rd(3'd4, "R1 status reset", 32'd0);
    rd(3'd3, "R1 attr reset", 32'd0);

    wr(3'd1, 32'd2);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, "R1 attr mask", 32'h173F_FF3F);
    wr(3'd2, 32'h1234_5678);
    rd(3'd2, "R2 base low bits", 32'h1234_5660);
    rd(3'd1, "R2 index readback", 32'd2);
    wr(3'd1, 32'd5);
    rd(3'd3, "R2 other region untouched", 32'd0);

    region(0, 32'h0000_0000, 32'h0500_0023);
    region(1, 32'h2000_0000, 32'h1300_001D);
    region(2, 32'h2000_0000, 32'h0000_000F);
    region(3, 32'h4000_0000, 32'h1100_0239);
    region(4, 32'h6000_0000, 32'h063F_0005);
    region(5, 32'h8000_0000, 32'h0200_0013);
    region(6, 32'h9000_0000, 32'h0400_0009);
    region(7, 32'h8000_0000, 32'h0300_0012);
    wr(3'd1, 32'd4);
    rd(3'd3, "R13 type bits readback", 32'h063F_0005);

    for (int v = 0; v < NV; v++) begin
      wr(3'd0, {29'd0, VEC[v][43:41]});
      access(VEC[v][40:9], VEC[v][8:5]);
      n_chk++;
      if (acc_permit !== VEC[v][4] || acc_fault !== !VEC[v][4]) begin
        n_bad++;
        $display("FAIL R%0d vector %0d actual=permit %b fault %b expected=permit %b",
                 VEC[v][3:0], v, acc_permit, acc_fault, VEC[v][4]);
      end
      finish_access();
    end

    // R11 idle access produces no result
    acc_addr = 32'h9000_0000; acc_valid = 1'b0; #1;
    check("R11 idle", {30'd0, acc_permit, acc_fault}, 32'd0);

    wr(3'd0, 32'd1);
    wr(3'd4, 32'd1);
    rd(3'd4, "R12 clear", 32'd0);
    access(32'h2000_1000, 4'b0000);
    finish_access();
    rd(3'd4, "R11 permit no capture", 32'd0);
    access(32'h0000_1000, 4'b0000);
    finish_access();
    rd(3'd4, "R11 flag set", 32'd1);
    rd(3'd5, "R11 address stored", 32'h0000_1000);
    access(32'h2000_0080, 4'b0010);
    finish_access();
    rd(3'd5, "R12 sticky address", 32'h0000_1000);
    wr(3'd4, 32'd1);
    rd(3'd4, "R12 flag cleared", 32'd0);
    access(32'h2000_0080, 4'b0010);
    finish_access();
    rd(3'd4, "R11 flag set again", 32'd1);
    rd(3'd5, "R11 new address", 32'h2000_0080);

    summary();
  end
endmodule